// File: doc/BRIEF.md
# All-Pairs Rank Sorter

This block sorts a set of N unsigned values in a fixed number of cycles, no matter what the data is. It does not use a network of compare-exchange stages. Instead it compares every element against every other element at the same time. For each element it counts how many others must be placed ahead of it, and that count is the element's output slot. Each value is then routed straight to its slot. Equal values are ordered by their input index, so no two elements ever share a slot.

A producer raises `in_valid` for one cycle alongside a packed vector of N values. Two clock edges later `out_valid` pulses for one cycle. At that point `out_data` holds the values in ascending order and `out_rank` holds the slot assigned to each input. A new vector may be accepted on every cycle. The outputs keep their last result until the next result arrives.

Top module: `rank_sorter`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `out_data` and `out_rank` are all zero.
- R2: A vector sampled with `in_valid` high at clock edge k makes `out_valid` high for exactly the cycle after edge k+1. Vectors on consecutive cycles give results on consecutive cycles.
- R3: When `out_valid` is high, `out_data` is non-decreasing from slot 0 upward. Slot s sits at bits [s*W +: W], so slot 0 is the lowest W bits and holds the smallest value.
- R4: Input element i sits at `in_data[i*W +: W]`. Its rank is written to `out_rank[i*RW +: RW]`, where RW = ceil(log2 N). The rank equals the number of elements j for which a[j] < a[i], or for which a[j] == a[i] and j < i.
- R5: Elements with equal values receive distinct ranks, and the ranks increase with input index.
- R6: The N ranks in one result always form a permutation of 0..N-1.
- R7: For every element i, output slot `out_rank[i]` holds the input value a[i].
- R8: In a cycle where `out_valid` is low, `out_data` and `out_rank` keep the values they had in the previous cycle.
- R9: Values are compared as unsigned magnitudes, so a value with its top bit set sorts above any value with that bit clear.
- R10: The input 1,7,3,9,3,0 (element 0 first) gives ranks 1,4,2,5,3,0 and the sorted output 0,1,3,3,7,9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_data` as a vector to sort |
| in_data | input | N*W | Packed input values, element i at bits [i*W +: W] |
| out_valid | output | 1 | One-cycle pulse when a sorted result is present |
| out_data | output | N*W | Sorted values, slot 0 (the smallest) in the lowest bits |
| out_rank | output | N*RW | Slot given to each input element, element i at bits [i*RW +: RW] |

## Verification
On every clock, the assertions check the following properties:
- the two-edge valid latency;
- that the outputs hold between results;
- that each result is ordered;
- that its ranks are a permutation;
- that each input value lands in the slot its rank names;
- that equal inputs keep their index order.

The checker finds these by tracking captured inputs itself. The bench scenarios are needed for the exact rank values of the worked example, for the unsigned treatment of the top bit, for the reset state, and for agreement with an independent stable sort across many random vectors, including back-to-back vectors.

// File: rtl/rsort_pkg.sv
package rsort_pkg;

  // Width of a rank field able to hold 0..n-1 (at least one bit).
  function automatic int rank_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rsort_cmp_matrix.sv
// All-pairs precedence matrix: bit [i*N+j] is set when element i must be
// placed after element j. Ties are broken by index, so the lower index wins.
module rsort_cmp_matrix #(
  parameter int N = 6,
  parameter int W = 8
) (
  input  logic [N*W-1:0] vals,
  output logic [N*N-1:0] after_mat
);

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign after_mat[i*N+j] = 1'b0;
      end else if (j < i) begin : g_lower
        // equal values: higher index goes after
        assign after_mat[i*N+j] = (vals[i*W +: W] >= vals[j*W +: W]);
      end else begin : g_upper
        assign after_mat[i*N+j] = (vals[i*W +: W] > vals[j*W +: W]);
      end
    end
  end

endmodule

// File: rtl/rsort_rank_count.sv
// Row population counts of the precedence matrix give each element's slot.
module rsort_rank_count #(
  parameter int N  = 6,
  parameter int RW = 3
) (
  input  logic [N*N-1:0]  after_mat,
  output logic [N*RW-1:0] ranks
);

  for (genvar r = 0; r < N; r++) begin : g_cnt
    logic [RW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < N; j++) begin
        acc = acc + RW'(after_mat[r*N+j]);
      end
    end
    assign ranks[r*RW +: RW] = acc;
  end

endmodule

// File: rtl/rsort_scatter.sv
// Routes every value to the output slot named by its rank. Ranks are a
// permutation, so exactly one element matches each slot.
module rsort_scatter #(
  parameter int N  = 6,
  parameter int W  = 8,
  parameter int RW = 3
) (
  input  logic [N*W-1:0]  vals,
  input  logic [N*RW-1:0] ranks,
  output logic [N*W-1:0]  sorted
);

  for (genvar s = 0; s < N; s++) begin : g_slot
    logic [W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++) begin
        if (ranks[i*RW +: RW] == RW'(s)) begin
          acc = acc | vals[i*W +: W];
        end
      end
    end
    assign sorted[s*W +: W] = acc;
  end

endmodule

// File: rtl/rank_sorter.sv
// Two-stage rank sorter: input register, then all-pairs compare, row count
// and scatter in one combinational pass, then output register.
module rank_sorter #(
  parameter int N = 6,
  parameter int W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic [N*W-1:0]                   in_data,
  output logic                             out_valid,
  output logic [N*W-1:0]                   out_data,
  output logic [N*rsort_pkg::rank_w(N)-1:0] out_rank
);

  localparam int RW = rsort_pkg::rank_w(N);

  logic           stg_vld;
  logic [N*W-1:0] stg_data;
  logic [N*N-1:0] after_mat;
  logic [N*RW-1:0] rank_c;
  logic [N*W-1:0] sorted_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vld  <= 1'b0;
      stg_data <= '0;
    end else begin
      stg_vld <= in_valid;
      if (in_valid) stg_data <= in_data;
    end
  end

  rsort_cmp_matrix #(.N(N), .W(W)) u_cmp (
    .vals      (stg_data),
    .after_mat (after_mat)
  );

  rsort_rank_count #(.N(N), .RW(RW)) u_cnt (
    .after_mat (after_mat),
    .ranks     (rank_c)
  );

  rsort_scatter #(.N(N), .W(W), .RW(RW)) u_scat (
    .vals   (stg_data),
    .ranks  (rank_c),
    .sorted (sorted_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_rank  <= '0;
    end else begin
      out_valid <= stg_vld;
      if (stg_vld) begin
        out_data <= sorted_c;
        out_rank <= rank_c;
      end
    end
  end

endmodule

// File: rtl/rank_sorter_chk.sv
module rank_sorter_chk #(
  parameter int N = 6,
  parameter int W = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              in_valid,
  input logic [N*W-1:0]                    in_data,
  input logic                              out_valid,
  input logic [N*W-1:0]                    out_data,
  input logic [N*rsort_pkg::rank_w(N)-1:0] out_rank
);

  localparam int RW = rsort_pkg::rank_w(N);

  logic           v1, v2, rst_q;
  logic [N*W-1:0] cap1, cap2;
  logic [N-1:0]   seen;
  logic           sorted_ok, place_ok, tie_ok;

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; cap1 <= '0; cap2 <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      if (in_valid) cap1 <= in_data;
      if (v1) cap2 <= cap1;
    end
  end

  always_comb begin
    seen = '0;
    sorted_ok = 1'b1;
    place_ok = 1'b1;
    tie_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (int'(out_rank[i*RW +: RW]) < N) begin
        seen[out_rank[i*RW +: RW]] = 1'b1;
        if (out_data[out_rank[i*RW +: RW]*W +: W] != cap2[i*W +: W]) place_ok = 1'b0;
      end else begin
        place_ok = 1'b0;
      end
      for (int j = i + 1; j < N; j++) begin
        if (cap2[i*W +: W] == cap2[j*W +: W] &&
            out_rank[i*RW +: RW] >= out_rank[j*RW +: RW]) tie_ok = 1'b0;
      end
    end
    for (int s = 1; s < N; s++) begin
      if (out_data[s*W +: W] < out_data[(s-1)*W +: W]) sorted_ok = 1'b0;
    end
  end

  // R1: outputs cleared after a reset edge
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      a_r1_reset_clear: assert (out_valid == 1'b0 && out_data == '0 && out_rank == '0);
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == v2);

  a_r3_ordered: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> sorted_ok);

  a_r5_tie_order: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> tie_ok);

  a_r6_permutation: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen == {N{1'b1}}));

  a_r7_placement: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> place_ok);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_data) && $stable(out_rank)));

endmodule

bind rank_sorter rank_sorter_chk #(.N(N), .W(W)) u_rank_sorter_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_rank  (out_rank)
);

// File: tb/test_rank_sorter.sv
`timescale 1ns/1ps
module test_rank_sorter;

  localparam int N  = 6;
  localparam int W  = 8;
  localparam int RW = 3;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [N*W-1:0]  in_data;
  logic            out_valid;
  logic [N*W-1:0]  out_data;
  logic [N*RW-1:0] out_rank;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rank_sorter #(.N(N), .W(W)) i_rank_sorter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_rank(out_rank)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] pk(input int a0, a1, a2, a3, a4, a5);
    return {W'(a5), W'(a4), W'(a3), W'(a2), W'(a1), W'(a0)};
  endfunction

  function automatic logic [N*RW-1:0] pr(input int r0, r1, r2, r3, r4, r5);
    return {RW'(r5), RW'(r4), RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
  endfunction

  // Reference: stable insertion sort of indices.
  task automatic ref_sort(input logic [N*W-1:0] d, output logic [N*W-1:0] s, output logic [N*RW-1:0] r);
    int ord[N];
    for (int k = 0; k < N; k++) ord[k] = k;
    for (int k = 1; k < N; k++) begin
      int key = ord[k];
      int m = k - 1;
      while (m >= 0 && d[ord[m]*W +: W] > d[key*W +: W]) begin
        ord[m+1] = ord[m];
        m--;
      end
      ord[m+1] = key;
    end
    s = '0; r = '0;
    for (int p = 0; p < N; p++) begin
      s[p*W +: W] = d[ord[p]*W +: W];
      r[ord[p]*RW +: RW] = RW'(p);
    end
  endtask

  // Cycle model: one-entry delay queue plus output register.
  bit              qv[$];
  logic [N*W-1:0]  qd[$];
  logic            exp_v = 1'b0;
  logic [N*W-1:0]  exp_d = '0;
  logic [N*RW-1:0] exp_r = '0;

  always @(posedge clk) begin
    if (rst) begin
      qv.delete(); qd.delete();
      qv.push_back(1'b0); qd.push_back('0);
      exp_v = 1'b0; exp_d = '0; exp_r = '0;
    end else begin
      bit pv;
      logic [N*W-1:0] pd;
      qv.push_back(in_valid); qd.push_back(in_data);
      pv = qv.pop_front(); pd = qd.pop_front();
      exp_v = pv;
      if (pv) ref_sort(pd, exp_d, exp_r);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(out_valid == exp_v, "R2 valid timing", 64'(out_valid), 64'(exp_v));
      chk(out_data == exp_d, "R3/R7 sorted data", 64'(out_data), 64'(exp_d));
      chk(out_rank == exp_r, "R4 ranks", 64'(out_rank), 64'(exp_r));
      if (out_valid) begin
        logic [N-1:0] m = '0;
        for (int i = 0; i < N; i++)
          if (int'(out_rank[i*RW +: RW]) < N) m[out_rank[i*RW +: RW]] = 1'b1;
        chk(m == {N{1'b1}}, "R6 permutation", 64'(m), 64'({N{1'b1}}));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic send(input logic [N*W-1:0] d);
    in_data = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [N*W-1:0] held_d;
    logic [N*RW-1:0] held_r;
    int seed = 12345;
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0 && out_rank == '0, "R1 reset state",
        64'(out_data), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R1 after reset", 64'(out_data), 64'(0));

    // R10 worked example, duplicates 3 at index 2 and 4 (R5)
    send(pk(1, 7, 3, 9, 3, 0));
    chk(out_valid == 1'b1, "R2 result pulse", 64'(out_valid), 64'(1));
    chk(out_rank == pr(1, 4, 2, 5, 3, 0), "R10 ranks", 64'(out_rank), 64'(pr(1, 4, 2, 5, 3, 0)));
    chk(out_data == pk(0, 1, 3, 3, 7, 9), "R10 sorted", 64'(out_data), 64'(pk(0, 1, 3, 3, 7, 9)));
    held_d = out_data; held_r = out_rank;

    // R8: outputs hold while idle
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R2 single pulse", 64'(out_valid), 64'(0));
    chk(out_data == held_d && out_rank == held_r, "R8 hold", 64'(out_data), 64'(held_d));

    // R9: unsigned compare
    send(pk(8'hFF, 8'h00, 8'h80, 8'h7F, 8'h01, 8'hFE));
    chk(out_data == pk(8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF), "R9 unsigned order",
        64'(out_data), 64'(pk(8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF)));
    chk(out_rank == pr(5, 0, 3, 2, 1, 4), "R9 unsigned ranks", 64'(out_rank), 64'(pr(5, 0, 3, 2, 1, 4)));

    // R5: all equal gives index order
    send(pk(5, 5, 5, 5, 5, 5));
    chk(out_rank == pr(0, 1, 2, 3, 4, 5), "R5 all equal", 64'(out_rank), 64'(pr(0, 1, 2, 3, 4, 5)));

    // R2: back-to-back vectors
    in_data = pk(6, 5, 4, 3, 2, 1); in_valid = 1'b1;
    @(negedge clk);
    in_data = pk(9, 9, 1, 1, 0, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && out_rank == pr(5, 4, 3, 2, 1, 0), "R2 first of pair",
        64'(out_rank), 64'(pr(5, 4, 3, 2, 1, 0)));
    @(negedge clk);
    chk(out_valid == 1'b1 && out_rank == pr(4, 5, 2, 3, 0, 1), "R2 second of pair",
        64'(out_rank), 64'(pr(4, 5, 2, 3, 0, 1)));

    // Random traffic with narrow ranges for ties (R4, R5, R6, R7)
    for (int c = 0; c < 400; c++) begin
      logic [N*W-1:0] d;
      int mask;
      seed = seed * 1103515245 + 12345;
      mask = ((seed >>> 20) & 1) ? 8'h03 : 8'hFF;
      for (int e = 0; e < N; e++) begin
        seed = seed * 1103515245 + 12345;
        d[e*W +: W] = W'((seed >>> 16) & mask);
      end
      seed = seed * 1103515245 + 12345;
      in_valid = ((seed >>> 18) & 3) != 0;
      in_data = d;
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule